// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO with Composite Flags

This block builds one wide dual-clock FIFO out of two narrower FIFO slices of the same depth. The write clock, read clock, write enable, read enable, output enable and reset reach both slices in common. The low bits of each incoming word go to the first slice and the remaining high bits go to the second. The outgoing word is rebuilt from the two slice outputs, and each slice drives only its own field. Each slice is an asynchronous FIFO. It passes its pointers across the clock boundary in Gray code through two-flop synchronizers and computes each flag in the domain that uses it.

Two operating modes exist, and the mode input is sampled only while reset is asserted. In standard mode a read request moves the next word onto the output register. The read-side flag then acts as an active-low empty flag and the write-side flag as an active-low full flag. In first-word-fall-through mode the head word moves to the output without any request. The read-side flag then acts as an active-low output-ready flag and the write-side flag as an active-low input-ready flag. The two slice flags are combined so that the wide FIFO reports a blocking condition while either slice reports one. Standard mode uses AND on the active-low empty and full flags. Fall-through mode uses OR on the active-low ready flags. Every slice discards a request that the composite flag blocks, so the slices stay aligned. The half-full flag is taken from the first slice alone.

Top module: `split_width_fifo`

## Requirements
- R1: Bits [LO_W-1:0] of a written word are stored in slice 0 and bits [LO_W+HI_W-1:LO_W] in slice 1. Words come out in write order with each field back in its own position.
- R2: After reset in standard mode, readFlagN is 0, writeFlagN is 1, halfFullN is 1 and rdData is 0. After reset in fall-through mode, readFlagN is 1 and writeFlagN is 0.
- R3: In standard mode, readFlagN is 0 while either slice is empty. A read request while it is 0 is ignored, and rdData keeps its value.
- R4: In standard mode, writeFlagN goes to 0 as soon as DEPTH words are held. A write while it is 0 is ignored by both slices.
- R5: In fall-through mode, the oldest word appears on rdData with readFlagN at 0 without a read request. A read request is accepted only while readFlagN is 0, and a request while it is 1 is ignored.
- R6: In fall-through mode, writeFlagN goes to 1 once DEPTH+1 words are held, counting the output register. A write while it is 1 is ignored.
- R7: halfFullN is 0 while slice 0 holds at least DEPTH/2 words by its write-side count, and 1 otherwise.
- R8: While outEn is 0, rdData is all zeros. The FIFO contents are not disturbed, and the word comes back when outEn returns to 1.
- R9: fwftMode is sampled only while rstN is low. Changing it after reset does not change the operating mode.
- R10: In standard mode, rdData takes the next word at the read-clock edge where a read is accepted, and holds it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock, shared by both slices |
| rdClk | input | 1 | Read clock, shared by both slices |
| rstN | input | 1 | Asynchronous active-low reset, shared |
| fwftMode | input | 1 | 1 selects fall-through mode; sampled during reset |
| wrEn | input | 1 | Write request |
| wrData | input | LO_W+HI_W | Wide input word |
| rdEn | input | 1 | Read request |
| outEn | input | 1 | Output enable; 0 forces rdData to zero |
| rdData | output | LO_W+HI_W | Wide output word |
| readFlagN | output | 1 | Composite empty flag (standard) or output-ready flag (fall-through), active low |
| writeFlagN | output | 1 | Composite full flag (standard) or input-ready flag (fall-through), active low |
| halfFullN | output | 1 | Half-full flag of slice 0, active low |

## Verification
The bench sends ignored requests at both boundaries: a read while the FIFO is empty or not ready, and a write while it is full. A design that let a slice act on a blocked request would return a shifted or corrupted word on a later read. Because the fall-through capacity includes the output register, the bench checks that input-ready drops at exactly DEPTH+1 words. It also toggles the mode input after reset, which exposes a mode that is tracked live instead of latched. Long sweeps of computed values through both modes check that the two fields reassemble in the right positions.

// File: rtl/split_fifo_pkg.sv
package split_fifo_pkg;
  // strobes from a slice controller to its datapath
  typedef struct packed {
    logic push;   // write wrData into storage at the write address
    logic load;   // move storage head into the output register
  } sliceStrobe_t;
endpackage

// File: rtl/slice_data.sv
module slice_data #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic                        wrClk,
  input  logic                        rdClk,
  input  logic                        rstN,
  input  split_fifo_pkg::sliceStrobe_t wrStrb,
  input  split_fifo_pkg::sliceStrobe_t rdStrb,
  input  logic [AW-1:0]               wrAddr,
  input  logic [AW-1:0]               rdAddr,
  input  logic [W-1:0]                wrData,
  output logic [W-1:0]                outWord
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrStrb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            outWord <= '0;
    else if (rdStrb.load) outWord <= mem[rdAddr];
  end
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl #(
  parameter int AW = 4
) (
  input  logic                         wrClk,
  input  logic                         rdClk,
  input  logic                         rstN,
  input  logic                         modeW,
  input  logic                         modeR,
  input  logic                         wrAccept,
  input  logic                         rdAccept,
  output split_fifo_pkg::sliceStrobe_t wrStrb,
  output split_fifo_pkg::sliceStrobe_t rdStrb,
  output logic [AW-1:0]                wrAddr,
  output logic [AW-1:0]                rdAddr,
  output logic                         rdFlag,
  output logic                         wrFlag,
  output logic                         halfFullN
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF = PW'(1 << (AW - 1));

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGraySyncA, rdGraySyncB, rdBinSync;
  logic [PW-1:0] wrGraySyncA, wrGraySyncB;
  logic [PW-1:0] fillLevel;
  logic memFull, memEmpty, outValid;

  // write domain
  always_comb begin
    memFull   = (wrGray == {~rdGraySyncB[PW-1:PW-2], rdGraySyncB[PW-3:0]});
    wrStrb.push = wrAccept;
    wrStrb.load = 1'b0;
    wrBinNext = wrBin + PW'(wrAccept);
    rdBinSync[PW-1] = rdGraySyncB[PW-1];
    for (int i = PW - 2; i >= 0; i--) rdBinSync[i] = rdBinSync[i+1] ^ rdGraySyncB[i];
    fillLevel = wrBin - rdBinSync;
    halfFullN = ~(fillLevel >= HALF);
    wrFlag    = modeW ? memFull : ~memFull;
    wrAddr    = wrBin[AW-1:0];
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin <= '0; wrGray <= '0; rdGraySyncA <= '0; rdGraySyncB <= '0;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= wrBinNext ^ (wrBinNext >> 1);
      rdGraySyncA <= rdGray;
      rdGraySyncB <= rdGraySyncA;
    end
  end

  // read domain
  always_comb begin
    memEmpty    = (rdGray == wrGraySyncB);
    rdStrb.push = 1'b0;
    if (modeR) rdStrb.load = !memEmpty && (!outValid || rdAccept);
    else       rdStrb.load = rdAccept;
    rdBinNext = rdBin + PW'(rdStrb.load);
    rdFlag    = modeR ? ~outValid : ~memEmpty;
    rdAddr    = rdBin[AW-1:0];
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin <= '0; rdGray <= '0; wrGraySyncA <= '0; wrGraySyncB <= '0; outValid <= 1'b0;
    end else begin
      rdBin       <= rdBinNext;
      rdGray      <= rdBinNext ^ (rdBinNext >> 1);
      wrGraySyncA <= wrGray;
      wrGraySyncB <= wrGraySyncA;
      if (!modeR)           outValid <= 1'b0;
      else if (rdStrb.load) outValid <= 1'b1;
      else if (rdAccept)    outValid <= 1'b0;
    end
  end

  // R4 / R6: storage never written while full
  assert_no_overflow_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    wrStrb.push |-> !memFull);
  // R3 / R5: storage never popped while empty
  assert_no_underflow_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    rdStrb.load |-> !memEmpty);
  // R5: a presented word stays presented until a read takes it
  assert_fwft_hold_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeR && outValid && !rdAccept) |=> outValid);
endmodule

// File: rtl/split_width_fifo.sv
module split_width_fifo #(
  parameter int AW   = 4,
  parameter int LO_W = 8,
  parameter int HI_W = 10
) (
  input  logic                 wrClk,
  input  logic                 rdClk,
  input  logic                 rstN,
  input  logic                 fwftMode,
  input  logic                 wrEn,
  input  logic [LO_W+HI_W-1:0] wrData,
  input  logic                 rdEn,
  input  logic                 outEn,
  output logic [LO_W+HI_W-1:0] rdData,
  output logic                 readFlagN,
  output logic                 writeFlagN,
  output logic                 halfFullN
);
  localparam int TOTAL_W = LO_W + HI_W;
  localparam int NSLICE  = 2;

  logic modeW, modeR;
  logic [NSLICE-1:0] rdVec, wrVec, hfVec;
  logic rdBlock, wrBlock, rdAccept, wrAccept;
  logic [TOTAL_W-1:0] wideOut;

  // mode captured only while reset is held
  always_ff @(posedge wrClk) if (!rstN) modeW <= fwftMode;
  always_ff @(posedge rdClk) if (!rstN) modeR <= fwftMode;

  always_comb begin
    readFlagN  = modeR ? |rdVec : &rdVec;
    writeFlagN = modeW ? |wrVec : &wrVec;
    rdBlock    = modeR ? readFlagN  : ~readFlagN;
    wrBlock    = modeW ? writeFlagN : ~writeFlagN;
    rdAccept   = rdEn & ~rdBlock;
    wrAccept   = wrEn & ~wrBlock;
    rdData     = outEn ? wideOut : '0;
    halfFullN  = hfVec[0];
  end

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    localparam int W   = (s == 0) ? LO_W : HI_W;
    localparam int LSB = (s == 0) ? 0 : LO_W;
    split_fifo_pkg::sliceStrobe_t wrStrb, rdStrb;
    logic [AW-1:0] wrAddr, rdAddr;

    slice_ctrl #(.AW(AW)) ctrl_i (
      .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeW(modeW), .modeR(modeR),
      .wrAccept(wrAccept), .rdAccept(rdAccept), .wrStrb(wrStrb), .rdStrb(rdStrb),
      .wrAddr(wrAddr), .rdAddr(rdAddr), .rdFlag(rdVec[s]), .wrFlag(wrVec[s]),
      .halfFullN(hfVec[s])
    );

    slice_data #(.W(W), .AW(AW)) data_i (
      .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrStrb(wrStrb), .rdStrb(rdStrb),
      .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData[LSB +: W]),
      .outWord(wideOut[LSB +: W])
    );
  end

  // R7: aligned slices report the same fill state
  assert_slices_aligned_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    hfVec[0] == hfVec[1]);
  // R10: in standard mode the output word moves only on an accepted read
  assert_std_hold_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modeR && !rdAccept && outEn) |=> (!outEn || $stable(rdData)));
  // R3 / R5: composite flags agree with every slice's own flag
  assert_composite_read_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    rdAccept |-> (modeR ? (rdVec == '0) : (rdVec == '1)));
  // R4 / R6
  assert_composite_write_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    wrAccept |-> (modeW ? (wrVec == '0) : (wrVec == '1)));
endmodule

// File: tb/split_width_fifo_tb.sv
module split_width_fifo_tb_top;
  localparam int AW = 2, LO_W = 3, HI_W = 5, TW = LO_W + HI_W;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 0, rdClk = 0, rstN = 0, fwftMode = 0;
  logic wrEn = 0, rdEn = 0, outEn = 1;
  logic [TW-1:0] wrData = '0, rdData;
  logic readFlagN, writeFlagN, halfFullN;
  int checks = 0, fails = 0;

  always #2.5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  split_width_fifo #(.AW(AW), .LO_W(LO_W), .HI_W(HI_W)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .outEn(outEn), .rdData(rdData),
    .readFlagN(readFlagN), .writeFlagN(writeFlagN), .halfFullN(halfFullN));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic resetDut(input logic mode);
    rstN = 0; fwftMode = mode; wrEn = 0; rdEn = 0;
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
    rstN = 1;
    @(negedge rdClk);
  endtask

  task automatic doWrite(input logic [TW-1:0] v);
    @(negedge wrClk); wrEn = 1; wrData = v;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic doRead();
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic waitRd(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // ---------------- standard mode ----------------
    resetDut(1'b0);
    check(readFlagN == 0, "R2 empty after reset", readFlagN, 0);
    check(writeFlagN == 1, "R2 not full after reset", writeFlagN, 1);
    check(halfFullN == 1, "R2 halfFull after reset", halfFullN, 1);
    check(rdData == 0, "R2 rdData after reset", rdData, 0);
    fwftMode = 1;                                      // R9: must be ignored
    doRead();
    check(rdData == 0, "R3 read while empty ignored", rdData, 0);
    doWrite(8'hA5);
    waitRd(8);
    check(readFlagN == 1, "R3 not empty after write", readFlagN, 1);
    check(rdData == 0, "R9 no fall-through after mode change", rdData, 0);
    doRead();
    check(rdData == 8'hA5, "R10 read word", rdData, 8'hA5);
    check(readFlagN == 0, "R3 empty again", readFlagN, 0);
    doRead();
    check(rdData == 8'hA5, "R3 read on empty holds data", rdData, 8'hA5);
    fwftMode = 0;
    waitRd(8);
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(TW'(8'h10 + i));
      if (i == 0) check(halfFullN == 1, "R7 one word below half", halfFullN, 1);
      if (i == 1) check(halfFullN == 0, "R7 half reached", halfFullN, 0);
    end
    check(writeFlagN == 0, "R4 full at DEPTH", writeFlagN, 0);
    doWrite(8'hEE);                                    // R4: ignored
    waitRd(8);
    outEn = 0; #1;
    check(rdData == 0, "R8 outEn low zeros output", rdData, 0);
    outEn = 1; #1;
    check(rdData == 8'hA5, "R8 output restored", rdData, 8'hA5);
    for (int i = 0; i < DEPTH; i++) begin
      doRead();
      check(rdData == TW'(8'h10 + i), "R4 R10 word order after full", rdData, 8'h10 + i);
    end
    check(readFlagN == 0, "R4 extra write was dropped", readFlagN, 0);
    waitRd(8);
    check(writeFlagN == 1, "R4 space after drain", writeFlagN, 1);
    check(halfFullN == 1, "R7 below half after drain", halfFullN, 1);
    for (int i = 0; i < 256; i++) begin
      logic [TW-1:0] v;
      v = TW'((i * 29 + 7) % 256);
      doWrite(v);
      waitRd(6);
      doRead();
      check(rdData == v, "R1 standard sweep", rdData, v);
    end

    // ---------------- fall-through mode ----------------
    resetDut(1'b1);
    check(readFlagN == 1, "R2 fwft not ready after reset", readFlagN, 1);
    check(writeFlagN == 0, "R2 fwft input ready after reset", writeFlagN, 0);
    fwftMode = 0;                                      // R9: must be ignored
    doRead();                                          // R5: ignored, not ready
    doWrite(8'h3C);
    waitRd(8);
    check(readFlagN == 0, "R5 output ready without read", readFlagN, 0);
    check(rdData == 8'h3C, "R5 R9 word falls through", rdData, 8'h3C);
    doRead();
    check(readFlagN == 1, "R5 not ready after last read", readFlagN, 1);
    doWrite(8'h40);
    waitRd(8);
    for (int i = 1; i <= DEPTH; i++) doWrite(TW'(8'h40 + i));
    check(writeFlagN == 1, "R6 input not ready at DEPTH+1", writeFlagN, 1);
    doWrite(8'h99);                                    // R6: ignored
    waitRd(8);
    for (int i = 0; i <= DEPTH; i++) begin
      check(readFlagN == 0, "R5 ready while data held", readFlagN, 0);
      check(rdData == TW'(8'h40 + i), "R6 word order after full", rdData, 8'h40 + i);
      doRead();
      waitRd(2);
    end
    check(readFlagN == 1, "R6 extra write was dropped", readFlagN, 1);
    for (int i = 0; i < 64; i++) begin
      logic [TW-1:0] v;
      v = TW'((i * 53 + 11) % 256);
      doWrite(v);
      waitRd(6);
      check(rdData == v, "R1 fall-through sweep", rdData, v);
      doRead();
    end
    report();
  end
endmodule